// File: doc/BRIEF.md
# Prioritized Exception Request Selector

This block decides, at an instruction boundary, whether a CPU core must take an exception and which one. It merges three request sources into a single registered decision. The first is a pending non-maskable request flag. The second is a vector of pending external interrupt levels. The third is an optional level from an internal peripheral, where the all-ones code means that no internal request is present.

The core pulses `chk_i` at each point where it may accept an exception, such as a block entry or a branch boundary. On the next clock edge the block registers its decision. It drives a one-cycle `take_o` pulse, the chosen level and a flag that marks the non-maskable case. When the non-maskable request wins, `nmi_ack_o` also pulses so that the core can clear its pending flag.

Comparison against the status-register mask is done upstream, and the vector fetch is done downstream. Neither is part of this block.

Top module: `irq_pick_top`

## Requirements
- R1: After reset, `take_o`, `is_nmi_o` and `nmi_ack_o` are 0 and `level_o` is all ones (-1).
- R2: A check with `nmi_i` high yields, one cycle later, `take_o`=1 and `is_nmi_o`=1 with `level_o` = MASK_W (32), whatever the other inputs are.
- R3: `nmi_ack_o` is high for exactly the cycles in which a non-maskable take is reported, and in no other cycle.
- R4: With `nmi_i` low and a non-zero mask, the external level is the index of the highest set bit of `ext_mask_i`, where bit 0 is level 0.
- R5: A check with `nmi_i` low and `ext_mask_i` zero yields `take_o`=0 and `level_o`=-1, even when an internal request is present.
- R6: An `int_lvl_i` of all ones (-1) means that no internal request is present. It never changes the result.
- R7: An internal level replaces the external one only when it is strictly greater than the external level. On an equal or lower internal level, the external level is reported.
- R8: `take_o` is high only in the cycle after a check. With `chk_i` low, `take_o` is 0 and `level_o` holds its last value.
- R9: An accepted non-NMI request reports `is_nmi_o`=0 and a `level_o` other than -1. Back-to-back checks each give their own take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chk_i | input | 1 | Evaluate the request sources in this cycle |
| nmi_i | input | 1 | A non-maskable request is pending |
| ext_mask_i | input | MASK_W | Pending external levels, one bit per level |
| int_lvl_i | input | LVL_W | Signed internal level; -1 means none |
| take_o | output | 1 | One-cycle pulse: take an exception |
| is_nmi_o | output | 1 | The exception taken is the non-maskable one |
| nmi_ack_o | output | 1 | One-cycle pulse to clear the pending NMI flag |
| level_o | output | LVL_W | Registered selected level; -1 when none |

## Verification
Every result of a check is due exactly one clock edge after the cycle in which `chk_i` is high, because the decision passes through a single output register. The bench drives inputs on the falling edge and lets one rising edge pass. It then reads the outputs on the following falling edge. It reads them again one cycle later, with `chk_i` low, to confirm that the pulses have ended and that the level is held. Random stimulus is compared against a priority function written from the requirements, which scans the mask from the top bit down.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_INT  = 2'd2,
        SRC_NMI  = 2'd3
    } pick_src_e;

    function automatic int lvl_bits(input int mask_w);
        return $clog2(mask_w) + 2;
    endfunction

endpackage

// File: rtl/irq_pick_lzc.sv
module irq_pick_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o,
    output logic          empty_o
);

    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = CW'(W - 1 - i);
        end
        empty_o = (cnt_o == CW'(W));
    end

endmodule

// File: rtl/irq_pick_merge.sv
module irq_pick_merge
    import irq_pick_pkg::*;
#(
    parameter int MASK_W = 32,
    parameter int LVL_W  = 7,
    parameter int CW     = $clog2(MASK_W + 1)
) (
    input  logic                    nmi_i,
    input  logic [CW-1:0]           lzc_i,
    input  logic                    empty_i,
    input  logic signed [LVL_W-1:0] int_lvl_i,
    output pick_src_e               src_o,
    output logic signed [LVL_W-1:0] lvl_o
);

    localparam logic signed [LVL_W-1:0] LVL_NONE = '1;
    localparam logic signed [LVL_W-1:0] LVL_NMI  = LVL_W'(MASK_W);
    localparam logic signed [LVL_W-1:0] LVL_TOP  = LVL_W'(MASK_W - 1);

    logic signed [LVL_W-1:0] ext_lvl;
    logic                    int_wins;

    always_comb begin
        ext_lvl  = LVL_TOP - $signed(LVL_W'(lzc_i));
        int_wins = (int_lvl_i != LVL_NONE) && (int_lvl_i > ext_lvl);
        if (nmi_i) begin
            src_o = SRC_NMI;
            lvl_o = LVL_NMI;
        end else if (empty_i) begin
            src_o = SRC_NONE;
            lvl_o = LVL_NONE;
        end else if (int_wins) begin
            src_o = SRC_INT;
            lvl_o = int_lvl_i;
        end else begin
            src_o = SRC_EXT;
            lvl_o = ext_lvl;
        end
    end

endmodule

// File: rtl/irq_pick_out.sv
module irq_pick_out
    import irq_pick_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    chk_i,
    input  pick_src_e               src_i,
    input  logic signed [LVL_W-1:0] lvl_i,
    output logic                    take_o,
    output logic                    is_nmi_o,
    output logic                    nmi_ack_o,
    output logic signed [LVL_W-1:0] level_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o    <= 1'b0;
            is_nmi_o  <= 1'b0;
            nmi_ack_o <= 1'b0;
            level_o   <= '1;
        end else if (chk_i) begin
            take_o    <= (src_i != SRC_NONE);
            is_nmi_o  <= (src_i == SRC_NMI);
            nmi_ack_o <= (src_i == SRC_NMI);
            level_o   <= lvl_i;
        end else begin
            take_o    <= 1'b0;
            is_nmi_o  <= 1'b0;
            nmi_ack_o <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int MASK_W = 32,
    parameter int LVL_W  = lvl_bits(MASK_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    chk_i,
    input  logic                    nmi_i,
    input  logic [MASK_W-1:0]       ext_mask_i,
    input  logic signed [LVL_W-1:0] int_lvl_i,
    output logic                    take_o,
    output logic                    is_nmi_o,
    output logic                    nmi_ack_o,
    output logic signed [LVL_W-1:0] level_o
);

    localparam int CW = $clog2(MASK_W + 1);

    logic [CW-1:0]           lzc;
    logic                    empty;
    pick_src_e               src;
    logic signed [LVL_W-1:0] lvl;

    irq_pick_lzc #(.W(MASK_W), .CW(CW)) u_lzc (
        .vec_i   (ext_mask_i),
        .cnt_o   (lzc),
        .empty_o (empty)
    );

    irq_pick_merge #(.MASK_W(MASK_W), .LVL_W(LVL_W), .CW(CW)) u_merge (
        .nmi_i     (nmi_i),
        .lzc_i     (lzc),
        .empty_i   (empty),
        .int_lvl_i (int_lvl_i),
        .src_o     (src),
        .lvl_o     (lvl)
    );

    irq_pick_out #(.LVL_W(LVL_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .chk_i     (chk_i),
        .src_i     (src),
        .lvl_i     (lvl),
        .take_o    (take_o),
        .is_nmi_o  (is_nmi_o),
        .nmi_ack_o (nmi_ack_o),
        .level_o   (level_o)
    );

endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk #(
    parameter int MASK_W = 32,
    parameter int LVL_W  = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    chk_i,
    input logic                    nmi_i,
    input logic [MASK_W-1:0]       ext_mask_i,
    input logic signed [LVL_W-1:0] int_lvl_i,
    input logic                    take_o,
    input logic                    is_nmi_o,
    input logic                    nmi_ack_o,
    input logic signed [LVL_W-1:0] level_o
);

    localparam logic signed [LVL_W-1:0] NONE = '1;

    a_r2_nmi_first: assert property (@(posedge clk) disable iff (rst)
        (chk_i && nmi_i) |=> (take_o && is_nmi_o && level_o == LVL_W'(MASK_W)));

    a_r3_ack_only_nmi: assert property (@(posedge clk) disable iff (rst)
        nmi_ack_o |-> (take_o && is_nmi_o));

    a_r3_ack_on_nmi: assert property (@(posedge clk) disable iff (rst)
        (take_o && is_nmi_o) |-> nmi_ack_o);

    a_r5_empty_none: assert property (@(posedge clk) disable iff (rst)
        (chk_i && !nmi_i && ext_mask_i == '0) |=> (!take_o && level_o == NONE));

    a_r8_no_chk_no_take: assert property (@(posedge clk) disable iff (rst)
        !chk_i |=> (!take_o && $stable(level_o)));

    a_r9_irq_level_valid: assert property (@(posedge clk) disable iff (rst)
        (take_o && !is_nmi_o) |-> (level_o != NONE));

endmodule

bind irq_pick_top irq_pick_chk #(.MASK_W(MASK_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chk_i      (chk_i),
    .nmi_i      (nmi_i),
    .ext_mask_i (ext_mask_i),
    .int_lvl_i  (int_lvl_i),
    .take_o     (take_o),
    .is_nmi_o   (is_nmi_o),
    .nmi_ack_o  (nmi_ack_o),
    .level_o    (level_o)
);

// File: tb/irq_pick_top_tb_top.sv
module irq_pick_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 32;
    localparam int LW = 7;
    localparam int NV = 9;

    // vector table: nmi, mask, internal level, expected take, nmi flag, level
    localparam logic          V_NMI  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [MW-1:0] V_MASK [NV] = '{32'h0000_0010, 32'h0000_0001, 32'h8000_0000,
                                              32'h0000_0100, 32'h0000_0100, 32'h0000_0100,
                                              32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
    localparam logic [LW-1:0] V_INT  [NV] = '{7'd5, 7'h7f, 7'h7f, 7'd9, 7'd8, 7'd3,
                                              7'd12, 7'h7f, 7'h7f};
    localparam logic          V_TAKE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic          V_ISN  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [LW-1:0] V_LVL  [NV] = '{7'd32, 7'd0, 7'd31, 7'd9, 7'd8, 7'd8,
                                              7'h7f, 7'h7f, 7'd32};
    localparam string         V_TAG  [NV] = '{"R2", "R4", "R4", "R7", "R7", "R7", "R5", "R6", "R2"};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 chk_i = 1'b0;
    logic                 nmi_i = 1'b0;
    logic [MW-1:0]        ext_mask_i = '0;
    logic signed [LW-1:0] int_lvl_i = '1;
    logic                 take_o, is_nmi_o, nmi_ack_o;
    logic signed [LW-1:0] level_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_pick_top #(.MASK_W(MW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .chk_i      (chk_i),
        .nmi_i      (nmi_i),
        .ext_mask_i (ext_mask_i),
        .int_lvl_i  (int_lvl_i),
        .take_o     (take_o),
        .is_nmi_o   (is_nmi_o),
        .nmi_ack_o  (nmi_ack_o),
        .level_o    (level_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Priority reference written from the requirements
    function automatic void ref_pick(input logic n, input logic [MW-1:0] m,
                                     input logic signed [LW-1:0] il,
                                     output logic t, output logic isn,
                                     output logic signed [LW-1:0] lv);
        int hi;
        hi = -1;
        for (int b = MW - 1; b >= 0; b--) begin
            if (m[b] && hi < 0) hi = b;
        end
        if (n) begin
            t = 1'b1; isn = 1'b1; lv = LW'(MW);
        end else if (hi < 0) begin
            t = 1'b0; isn = 1'b0; lv = '1;
        end else begin
            t = 1'b1; isn = 1'b0; lv = LW'(hi);
            if (il != -1 && int'(il) > hi) lv = il;
        end
    endfunction

    // apply one check, sample its result, then sample the following idle cycle
    task automatic do_check(input string tag, input logic n, input logic [MW-1:0] m,
                            input logic signed [LW-1:0] il, input logic et,
                            input logic en, input logic signed [LW-1:0] el);
        @(negedge clk);
        nmi_i = n; ext_mask_i = m; int_lvl_i = il; chk_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_i = 1'b0;
        check(tag, "take", int'(take_o), int'(et));
        check(tag, "is_nmi", int'(is_nmi_o), int'(en));
        check("R3", "nmi_ack", int'(nmi_ack_o), int'(en));
        check(tag, "level", int'(level_o), int'(el));
        @(posedge clk);
        @(negedge clk);
        check("R8", "take after", int'(take_o), 0);
        check("R3", "ack after", int'(nmi_ack_o), 0);
        check("R8", "level hold", int'(level_o), int'(el));
    endtask

    initial begin
        logic et, en;
        logic signed [LW-1:0] el;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "take", int'(take_o), 0);
        check("R1", "is_nmi", int'(is_nmi_o), 0);
        check("R1", "nmi_ack", int'(nmi_ack_o), 0);
        check("R1", "level", int'(level_o), -1);

        for (int v = 0; v < NV; v++) begin
            do_check(V_TAG[v], V_NMI[v], V_MASK[v], V_INT[v], V_TAKE[v], V_ISN[v], V_LVL[v]);
        end

        // R6: absent internal code with a mask leaves the external level
        do_check("R6", 1'b0, 32'h0000_2000, -7'sd1, 1'b1, 1'b0, 7'sd13);

        // R8: inputs change with no check, outputs stay put
        @(negedge clk);
        nmi_i = 1'b1; ext_mask_i = 32'hffff_ffff;
        @(posedge clk);
        @(negedge clk);
        check("R8", "no-chk take", int'(take_o), 0);
        check("R8", "no-chk level", int'(level_o), 13);
        nmi_i = 1'b0;

        // R9: back-to-back checks give two takes
        ext_mask_i = 32'h0000_0040; int_lvl_i = -7'sd1; chk_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", "b2b take 1", int'(take_o), 1);
        check("R9", "b2b level 1", int'(level_o), 6);
        ext_mask_i = 32'h0000_0400;
        @(posedge clk);
        @(negedge clk);
        chk_i = 1'b0;
        check("R9", "b2b take 2", int'(take_o), 1);
        check("R9", "b2b level 2", int'(level_o), 10);
        check("R9", "b2b is_nmi", int'(is_nmi_o), 0);

        // random patterns against the reference
        for (int k = 0; k < 300; k++) begin
            logic n;
            logic [MW-1:0] m;
            logic signed [LW-1:0] il;
            n = ($urandom_range(0, 7) == 0);
            m = $urandom();
            if ($urandom_range(0, 3) == 0) m = m >> $urandom_range(0, 31);
            if ($urandom_range(0, 5) == 0) m = '0;
            il = ($urandom_range(0, 2) == 0) ? -7'sd1 : LW'($urandom_range(0, 31));
            ref_pick(n, m, il, et, en, el);
            do_check("R7", n, m, il, et, en, el);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule